// File: doc/BRIEF.md
# Tagged Outstanding Load Tracker

This block sits between a processor's load port and a shared memory interface that may return data in any order. Every accepted load leaves on the memory side with a short transaction tag beside its address. The tracker remembers, for each tag, which destination register is waiting. When the memory side later returns data with a tag, the tracker looks that tag up, sends the data to the recorded destination, and frees the slot. Completion is matched by tag, not by arrival order, so a fast local hit can overtake a slow trip to shared memory.

Tags are handed out strictly in sequence from a wrapping pointer. The width of the tag sets how many loads can be in flight at once. Because allocation never skips ahead, one response that is still missing at the pointer position stalls new requests, even when later slots have already been freed. A response naming a slot that is not waiting is flagged as an error and then dropped.

Top module: `tag_tracker`

## Requirements
- R1: After a synchronous active-low reset, every slot is free, the next tag is 0, `req_ready` is 1, and `wb_valid` and `rsp_err` are 0.
- R2: A request is accepted in the cycle where `req_valid` and `req_ready` are both 1. In that same cycle `mem_req_valid` is 1, `mem_req_addr` equals `req_addr`, and `mem_req_tag` carries the tag just allocated. `mem_req_valid` is 0 in every other cycle.
- R3: Tags are issued in increasing order starting at 0 and wrap modulo 2^TAG_W. The tag advances by one only on an accepted request.
- R4: A response whose tag names a waiting slot drives `wb_valid`=1 in the same cycle, with `wb_dest` set to the destination recorded for that tag and `wb_data` set to `rsp_data`. The slot is freed at the next clock edge.
- R5: Responses may come back in any order, and each one is delivered to the destination of its own tag.
- R6: `req_ready` is 0 whenever the slot at the next tag position is still waiting and is not completing in this cycle, even if other slots are free.
- R7: With 2^TAG_W loads outstanding and no response arriving, `req_ready` is 0 and no further request is issued.
- R8: A response whose tag names a free slot raises `rsp_err` for that cycle and keeps `wb_valid` at 0. It changes no slot and does not move the next tag.
- R9: When the slot at the next tag position completes in the same cycle as a new request, the request is accepted into that slot. A later response with that tag is then delivered to the new destination.
- R10: A response and a request on different slots in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Load request present |
| req_addr | input | ADDR_W | Load address |
| req_dest | input | DEST_W | Destination register index |
| req_ready | output | 1 | Request can be accepted this cycle |
| mem_req_valid | output | 1 | Request issued to memory |
| mem_req_addr | output | ADDR_W | Address sent to memory |
| mem_req_tag | output | TAG_W | Tag sent with the address |
| rsp_valid | input | 1 | Memory response present |
| rsp_tag | input | TAG_W | Tag returned with the data |
| rsp_data | input | DATA_W | Returned load data |
| wb_valid | output | 1 | Data delivered to a destination |
| wb_dest | output | DEST_W | Destination register of the delivered data |
| wb_data | output | DATA_W | Delivered data |
| rsp_err | output | 1 | Response named a slot that was not waiting |

## Verification
On every cycle, the assertions check four things: an issued tag becomes a waiting slot, a completed slot becomes free, the tag steps by one after each issue, and an erroneous response leaves the table untouched. They also check that a full table with no completion stalls the requester. Only the directed scenarios can show that data reaches the right destination when responses return out of order. The same holds for the stall caused by a gap at the pointer while later slots are free, and for reuse of a slot in the very cycle it completes. For these, the bench compares the ports against its own model of the slots.

// File: rtl/tt_pkg.sv
// Package tt_pkg
// Purpose: default sizes shared by the tracker and its submodules.
// Assumes: the top module overrides these through its own parameters.
package tt_pkg;
    localparam int TT_TAG_W_DEF  = 3;
    localparam int TT_DEST_W_DEF = 5;
    localparam int TT_ADDR_W_DEF = 32;
    localparam int TT_DATA_W_DEF = 32;
endpackage

// File: rtl/tt_alloc.sv
// Module tt_alloc
// Purpose: holds the next tag to hand out and steps it on each accepted request.
// Assumes: the tag space is a power of two, so the tag wraps naturally.
module tt_alloc #(
    parameter int TAG_W = tt_pkg::TT_TAG_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [TAG_W-1:0] next_tag
);
    // step the allocation pointer on each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)       next_tag <= '0;
        else if (advance) next_tag <= next_tag + 1'b1;
    end
endmodule

// File: rtl/tt_table.sv
// Module tt_table
// Purpose: one waiting flag and one destination index per tag slot.
// Assumes: when a slot is freed and allocated in the same cycle, the
//          allocation wins and the slot stays waiting with its new destination.
module tt_table #(
    parameter int TAG_W  = tt_pkg::TT_TAG_W_DEF,
    parameter int DEST_W = tt_pkg::TT_DEST_W_DEF,
    localparam int SLOTS = 1 << TAG_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_en,
    input  logic [TAG_W-1:0]             alloc_tag,
    input  logic [DEST_W-1:0]            alloc_dest,
    input  logic                         free_en,
    input  logic [TAG_W-1:0]             free_tag,
    output logic [SLOTS-1:0]             pend_vec,
    output logic [SLOTS-1:0][DEST_W-1:0] dest_vec
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic set_here;
        logic clr_here;
        assign set_here = alloc_en && (alloc_tag == TAG_W'(g));
        assign clr_here = free_en  && (free_tag  == TAG_W'(g));

        // waiting flag: set on allocation, cleared on completion, set wins
        always_ff @(posedge clk) begin
            if (!rst_n)        pend_vec[g] <= 1'b0;
            else if (set_here) pend_vec[g] <= 1'b1;
            else if (clr_here) pend_vec[g] <= 1'b0;
        end

        // destination index captured on allocation
        always_ff @(posedge clk) begin
            if (!rst_n)        dest_vec[g] <= '0;
            else if (set_here) dest_vec[g] <= alloc_dest;
        end
    end

    AST_ALLOC_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> pend_vec[$past(alloc_tag)]); // R2

    AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (free_en && !(alloc_en && alloc_tag == free_tag)) |=> !pend_vec[$past(free_tag)]); // R4
endmodule

// File: rtl/tt_match.sv
// Module tt_match
// Purpose: looks up a returned tag and sorts the response into a hit
//          (deliver to the recorded destination) or a miss (error, drop).
// Assumes: the lookup is purely combinational and uses this cycle's table state.
module tt_match #(
    parameter int TAG_W  = tt_pkg::TT_TAG_W_DEF,
    parameter int DEST_W = tt_pkg::TT_DEST_W_DEF,
    localparam int SLOTS = 1 << TAG_W
) (
    input  logic                         rsp_valid,
    input  logic [TAG_W-1:0]             rsp_tag,
    input  logic [SLOTS-1:0]             pend_vec,
    input  logic [SLOTS-1:0][DEST_W-1:0] dest_vec,
    output logic                         hit,
    output logic                         miss,
    output logic [DEST_W-1:0]            hit_dest
);
    // classify the response and pick the waiting destination
    always_comb begin
        hit      = rsp_valid &&  pend_vec[rsp_tag];
        miss     = rsp_valid && !pend_vec[rsp_tag];
        hit_dest = dest_vec[rsp_tag];
    end
endmodule

// File: rtl/tag_tracker.sv
// Module tag_tracker
// Purpose: issues loads with sequential tags, records their destinations,
//          matches out-of-order responses by tag, and stalls when the slot
//          at the allocation pointer is still waiting.
// Assumes: a response and a request may share a cycle. A response that frees
//          the slot at the pointer lets that cycle's request reuse it.
module tag_tracker #(
    parameter int TAG_W  = tt_pkg::TT_TAG_W_DEF,
    parameter int DEST_W = tt_pkg::TT_DEST_W_DEF,
    parameter int ADDR_W = tt_pkg::TT_ADDR_W_DEF,
    parameter int DATA_W = tt_pkg::TT_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DEST_W-1:0] req_dest,
    output logic              req_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [TAG_W-1:0]  mem_req_tag,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              wb_valid,
    output logic [DEST_W-1:0] wb_dest,
    output logic [DATA_W-1:0] wb_data,
    output logic              rsp_err
);
    localparam int SLOTS = 1 << TAG_W;

    logic [TAG_W-1:0]             ptr;
    logic [SLOTS-1:0]             pend_vec;
    logic [SLOTS-1:0][DEST_W-1:0] dest_vec;
    logic                         hit;
    logic                         miss;
    logic [DEST_W-1:0]            hit_dest;
    logic                         accept;

    // ready when the pointer slot is free or is completing right now
    always_comb begin
        req_ready = !pend_vec[ptr] || (hit && rsp_tag == ptr);
        accept    = req_valid && req_ready;
    end

    // memory-side request and writeback outputs
    always_comb begin
        mem_req_valid = accept;
        mem_req_addr  = req_addr;
        mem_req_tag   = ptr;
        wb_valid      = hit;
        wb_dest       = hit_dest;
        wb_data       = rsp_data;
        rsp_err       = miss;
    end

    tt_alloc #(.TAG_W(TAG_W)) i_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (accept),
        .next_tag (ptr)
    );

    tt_table #(.TAG_W(TAG_W), .DEST_W(DEST_W)) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (accept),
        .alloc_tag  (ptr),
        .alloc_dest (req_dest),
        .free_en    (hit),
        .free_tag   (rsp_tag),
        .pend_vec   (pend_vec),
        .dest_vec   (dest_vec)
    );

    tt_match #(.TAG_W(TAG_W), .DEST_W(DEST_W)) i_match (
        .rsp_valid (rsp_valid),
        .rsp_tag   (rsp_tag),
        .pend_vec  (pend_vec),
        .dest_vec  (dest_vec),
        .hit       (hit),
        .miss      (miss),
        .hit_dest  (hit_dest)
    );

    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> (mem_req_tag == TAG_W'($past(mem_req_tag) + 1'b1))); // R3

    AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err && !mem_req_valid) |=> $stable(pend_vec) && $stable(ptr)); // R8

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((&pend_vec) && !wb_valid) |-> !req_ready); // R7

    AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> pend_vec[mem_req_tag]); // R6
endmodule

// File: tb/test_tag_tracker.sv
module test_tag_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W  = 3;
    localparam int DEST_W = 5;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int SLOTS  = 1 << TAG_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DEST_W-1:0] req_dest = '0;
    logic              req_ready;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [TAG_W-1:0]  mem_req_tag;
    logic              rsp_valid = 1'b0;
    logic [TAG_W-1:0]  rsp_tag = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              wb_valid;
    logic [DEST_W-1:0] wb_dest;
    logic [DATA_W-1:0] wb_data;
    logic              rsp_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // bench model of the slots
    bit              m_pend [SLOTS];
    logic [DEST_W-1:0] m_dest [SLOTS];
    logic [TAG_W-1:0]  m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_tracker #(.TAG_W(TAG_W), .DEST_W(DEST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tag_tracker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_dest(req_dest), .req_ready(req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_data(wb_data), .rsp_err(rsp_err)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one clock cycle: drive, check outputs against the model, advance model
    task automatic cycle(input string req, input bit rv_q, input logic [ADDR_W-1:0] a,
                         input logic [DEST_W-1:0] d, input bit rv_r,
                         input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] dat);
        bit exp_ready, acc, exp_wb, exp_err;
        @(negedge clk);
        req_valid = rv_q; req_addr = a; req_dest = d;
        rsp_valid = rv_r; rsp_tag = t; rsp_data = dat;
        #1;
        exp_wb    = rv_r && m_pend[t];
        exp_err   = rv_r && !m_pend[t];
        exp_ready = !m_pend[m_ptr] || (exp_wb && t == m_ptr);
        acc       = rv_q && exp_ready;
        chk(req, "req_ready", 64'(req_ready), 64'(exp_ready));
        chk(req, "mem_req_valid", 64'(mem_req_valid), 64'(acc));
        if (acc) begin
            chk(req, "mem_req_tag", 64'(mem_req_tag), 64'(m_ptr));
            chk(req, "mem_req_addr", 64'(mem_req_addr), 64'(a));
        end
        chk(req, "wb_valid", 64'(wb_valid), 64'(exp_wb));
        chk(req, "rsp_err", 64'(rsp_err), 64'(exp_err));
        if (exp_wb) begin
            chk(req, "wb_dest", 64'(wb_dest), 64'(m_dest[t]));
            chk(req, "wb_data", 64'(wb_data), 64'(dat));
        end
        if (exp_wb) m_pend[t] = 1'b0;
        if (acc) begin
            m_pend[m_ptr] = 1'b1;
            m_dest[m_ptr] = d;
            m_ptr = m_ptr + 1'b1;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < SLOTS; i++) begin m_pend[i] = 1'b0; m_dest[i] = '0; end
        m_ptr = '0;
        #1;
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
        chk("R1", "wb_valid", 64'(wb_valid), 64'd0);
        chk("R1", "rsp_err", 64'(rsp_err), 64'd0);
        chk("R1", "mem_req_valid idle", 64'(mem_req_valid), 64'd0);
        chk("R1", "first tag", 64'(mem_req_tag), 64'd0);
    endtask

    task automatic t_sequential_issue();
        cycle("R2", 1, 32'h1000, 5'd3, 0, 0, 0);
        cycle("R3", 1, 32'h1004, 5'd4, 0, 0, 0);
        cycle("R3", 1, 32'h1008, 5'd5, 0, 0, 0);
        cycle("R2", 0, 32'h0, 5'd0, 0, 0, 0);
        chk("R3", "tag after three", 64'(mem_req_tag), 64'd3);
    endtask

    task automatic t_out_of_order();
        cycle("R5", 0, 0, 0, 1, 3'd2, 32'hCCCC0002);
        chk("R5", "dest of tag 2", 64'(wb_dest), 64'd5);
        cycle("R4", 0, 0, 0, 1, 3'd0, 32'hAAAA0000);
        chk("R4", "dest of tag 0", 64'(wb_dest), 64'd3);
        cycle("R5", 0, 0, 0, 1, 3'd1, 32'hBBBB0001);
        chk("R5", "dest of tag 1", 64'(wb_dest), 64'd4);
    endtask

    task automatic t_bad_tag();
        cycle("R8", 0, 0, 0, 1, 3'd0, 32'hDEAD0000);
        chk("R8", "err on free slot", 64'(rsp_err), 64'd1);
        cycle("R8", 1, 32'h2000, 5'd9, 0, 0, 0);
        chk("R8", "tag unmoved by error", 64'(mem_req_tag), 64'd3);
        cycle("R8", 0, 0, 0, 1, 3'd3, 32'h33);
        cycle("R8", 0, 0, 0, 1, 3'd3, 32'h34);
        chk("R8", "second response is error", 64'(rsp_err), 64'd1);
        chk("R8", "second response not written", 64'(wb_valid), 64'd0);
    endtask

    task automatic t_full_and_gap();
        for (int i = 0; i < SLOTS; i++)
            cycle("R3", 1, 32'h3000 + 32'(i*4), 5'(10 + i), 0, 0, 0);
        cycle("R7", 1, 32'h4000, 5'd30, 0, 0, 0);
        chk("R7", "full table stalls", 64'(req_ready), 64'd0);
        chk("R7", "no issue when full", 64'(mem_req_valid), 64'd0);
        cycle("R5", 0, 0, 0, 1, 3'd5, 32'h55);
        cycle("R6", 1, 32'h4000, 5'd30, 0, 0, 0);
        chk("R6", "gap at pointer stalls", 64'(req_ready), 64'd0);
        cycle("R9", 1, 32'h4100, 5'd31, 1, 3'd4, 32'h44);
        chk("R9", "reuse same cycle accepted", 64'(mem_req_valid), 64'd1);
        chk("R9", "reused tag", 64'(mem_req_tag), 64'd4);
        chk("R9", "old dest delivered", 64'(wb_dest), 64'd10);
        cycle("R10", 1, 32'h4200, 5'd22, 1, 3'd6, 32'h66);
        chk("R10", "request issued", 64'(mem_req_valid), 64'd1);
        chk("R10", "response delivered", 64'(wb_valid), 64'd1);
        cycle("R9", 0, 0, 0, 1, 3'd4, 32'h4444);
        chk("R9", "new dest on reused tag", 64'(wb_dest), 64'd31);
        cycle("R6", 0, 0, 0, 0, 0, 0);
        chk("R6", "pointer slot free gives ready", 64'(req_ready), 64'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sequential_issue();
        t_out_of_order();
        t_bad_tag();
        t_full_and_gap();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule